// File: doc/BRIEF.md
# USB Hub Downstream Port Override

This block gives software direct control over the D+ and D- lines of four USB hub downstream ports, and it reports the live line state of each port. A small processor register interface (address, write strobe, write data, combinational read data) reaches four registers. The first is a drive-code register with a 2-bit code per port. It can release a port to normal traffic or force differential 1, differential 0 or SE0. The second is a force-low register with one bit per line, which holds individual lines low. The last two are read-only: a per-port SE0 status register and a per-port differential data register.

The two override paths sit in different reset domains. A USB bus reset clears the drive codes and the line-state registers, but the force-low register survives it. Only chip reset clears the force-low register. The line-state inputs from the transceivers pass through a two-stage synchronizer before classification. The data register follows D+ while the port shows a differential state. It freezes on the last differential value while the port is in SE0 or while both lines are high.

Top module: `hpo_port_override`

## Requirements
- R1: Each port's 2-bit drive code acts on both of its lines: 00 releases them (output enables low); 01 drives D+ high and D- low; 10 drives D+ low and D- high; 11 drives both lines low. All driven lines have their output enable high.
- R2: The drive-code register sits at address 0. Port n (n = 1..4) uses bits 2n-1:2n-2, so port 1 uses bits 1:0 and port 4 uses bits 7:6.
- R3: The force-low register sits at address 1. Bit 2n-2 is D- of port n and bit 2n-1 is D+ of port n. A set bit enables that line and drives it low, whatever the drive code for that port says.
- R4: Chip reset (rst_n low, asynchronous) clears all four registers and releases every line.
- R5: A bus reset pulse (bus_rst high at a clock edge) clears the drive-code, SE0 status and data registers but leaves the force-low register unchanged.
- R6: The SE0 status register sits at address 2. Bit n-1 is 1 while port n has both lines low, and bits 7:4 read 0. A line change shows up in this register after the third rising clock edge (two synchronizer stages plus the status register).
- R7: The data register sits at address 3. Bit n-1 holds the D+ level of the last differential state (D+ not equal to D-) seen on port n. It keeps that value while the port is in SE0 or has both lines high.
- R8: Writes to addresses 2 and 3 have no effect, and a read of any address other than 0 to 3 returns 0.
- R9: The drive-code and force-low registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous |
| bus_rst | input | 1 | USB bus reset, active high, synchronous |
| addr | input | 8 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| line_dp | input | 4 | Received D+ level per port, asynchronous |
| line_dm | input | 4 | Received D- level per port, asynchronous |
| dp_oe | output | 4 | D+ drive enable per port |
| dp_out | output | 4 | D+ drive value per port |
| dm_oe | output | 4 | D- drive enable per port |
| dm_out | output | 4 | D- drive value per port |

## Verification
The line-state properties assume that the line inputs have already passed the synchronizer. They also assume that bus_rst is a synchronous pulse, so every hold and track check is gated by bus_rst being low. The bench changes the line inputs and bus_rst only on falling clock edges. It waits at least three rising edges before it reads a line-state register, except in the one test that pins the latency down exactly. The drive properties assume that no write lands in the same cycle as the check. The stimulus therefore holds wr_en low whenever it samples the outputs.

// File: rtl/hpo_pkg.sv
package hpo_pkg;
   typedef enum logic [1:0] {
      DRV_RELEASE = 2'b00,
      DRV_DIFF1   = 2'b01,
      DRV_DIFF0   = 2'b10,
      DRV_SE0     = 2'b11
   } drv_code_e;

   typedef struct packed {
      logic dp_oe;
      logic dp_out;
      logic dm_oe;
      logic dm_out;
   } line_drive_t;
endpackage

// File: rtl/hpo_sync.sv
module hpo_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("hpo_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/hpo_drive.sv
module hpo_drive
   import hpo_pkg::*;
(
   input  logic [1:0]  code,
   input  logic        low_dp,
   input  logic        low_dm,
   output line_drive_t drv
);
   line_drive_t base;

   always_comb begin
      base = '0;
      case (drv_code_e'(code))
         DRV_DIFF1: base = '{dp_oe: 1'b1, dp_out: 1'b1, dm_oe: 1'b1, dm_out: 1'b0};
         DRV_DIFF0: base = '{dp_oe: 1'b1, dp_out: 1'b0, dm_oe: 1'b1, dm_out: 1'b1};
         DRV_SE0:   base = '{dp_oe: 1'b1, dp_out: 1'b0, dm_oe: 1'b1, dm_out: 1'b0};
         default:   base = '0;
      endcase
   end

   always_comb begin
      drv = base;
      if (low_dp) begin
         drv.dp_oe  = 1'b1;
         drv.dp_out = 1'b0;
      end
      if (low_dm) begin
         drv.dm_oe  = 1'b1;
         drv.dm_out = 1'b0;
      end
   end
endmodule

// File: rtl/hpo_linemon.sv
module hpo_linemon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_rst,
   input  logic dp_raw,
   input  logic dm_raw,
   output logic se0_q,
   output logic data_q
);
   logic [1:0] sync_q;
   logic       dp_s, dm_s, is_se0, is_diff;

   hpo_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({dp_raw, dm_raw}),
      .q     (sync_q)
   );

   assign dp_s    = sync_q[1];
   assign dm_s    = sync_q[0];
   assign is_se0  = !dp_s && !dm_s;
   assign is_diff = dp_s ^ dm_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         se0_q  <= 1'b0;
         data_q <= 1'b0;
      end else if (bus_rst) begin
         se0_q  <= 1'b0;
         data_q <= 1'b0;
      end else begin
         se0_q <= is_se0;
         if (is_diff) data_q <= dp_s;
      end
   end

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rst && !is_diff) |=> $stable(data_q)); // R7
   AST_DATA_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rst && is_diff) |=> (data_q == $past(dp_s))); // R7
   AST_BUS_RST_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (!se0_q && !data_q)); // R5
endmodule

// File: rtl/hpo_port_override.sv
module hpo_port_override
   import hpo_pkg::*;
#(
   parameter int NPORTS      = 4,
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 8,
   parameter int ADDR_CTRL   = 0,
   parameter int ADDR_FLOW   = 1,
   parameter int ADDR_SE0    = 2,
   parameter int ADDR_DATA   = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [NPORTS-1:0] line_dp,
   input  logic [NPORTS-1:0] line_dm,
   output logic [NPORTS-1:0] dp_oe,
   output logic [NPORTS-1:0] dp_out,
   output logic [NPORTS-1:0] dm_oe,
   output logic [NPORTS-1:0] dm_out
);
   localparam int FIELD_BITS = 2 * NPORTS;

   if (FIELD_BITS > DATA_W) begin : g_bad_width
      $error("hpo_port_override: 2*NPORTS exceeds DATA_W");
   end
   if (ADDR_CTRL == ADDR_FLOW || ADDR_CTRL == ADDR_SE0 || ADDR_CTRL == ADDR_DATA ||
       ADDR_FLOW == ADDR_SE0  || ADDR_FLOW == ADDR_DATA || ADDR_SE0 == ADDR_DATA) begin : g_bad_map
      $error("hpo_port_override: register addresses must differ");
   end

   logic [FIELD_BITS-1:0] ctrl_q, flow_q;
   logic [NPORTS-1:0]     se0_vec, data_vec;
   logic                  ctrl_wr, flow_wr;

   assign ctrl_wr = wr_en && (addr == ADDR_W'(ADDR_CTRL));
   assign flow_wr = wr_en && (addr == ADDR_W'(ADDR_FLOW));

   // drive-code register: cleared by both resets
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (bus_rst) ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= wdata[FIELD_BITS-1:0];
   end

   // force-low register: chip reset only
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flow_q <= '0;
      else if (flow_wr) flow_q <= wdata[FIELD_BITS-1:0];
   end

   always_comb begin
      if (addr == ADDR_W'(ADDR_CTRL))      rdata = DATA_W'(ctrl_q);
      else if (addr == ADDR_W'(ADDR_FLOW)) rdata = DATA_W'(flow_q);
      else if (addr == ADDR_W'(ADDR_SE0))  rdata = DATA_W'(se0_vec);
      else if (addr == ADDR_W'(ADDR_DATA)) rdata = DATA_W'(data_vec);
      else                                 rdata = '0;
   end

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      line_drive_t drv;

      hpo_drive u_drive (
         .code   (ctrl_q[2*p+1:2*p]),
         .low_dp (flow_q[2*p+1]),
         .low_dm (flow_q[2*p]),
         .drv    (drv)
      );

      assign dp_oe[p]  = drv.dp_oe;
      assign dp_out[p] = drv.dp_out;
      assign dm_oe[p]  = drv.dm_oe;
      assign dm_out[p] = drv.dm_out;

      hpo_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
         .clk     (clk),
         .rst_n   (rst_n),
         .bus_rst (bus_rst),
         .dp_raw  (line_dp[p]),
         .dm_raw  (line_dm[p]),
         .se0_q   (se0_vec[p]),
         .data_q  (data_vec[p])
      );

      AST_LOW_WINS_DP: assert property (@(posedge clk) disable iff (!rst_n)
         flow_q[2*p+1] |-> (dp_oe[p] && !dp_out[p])); // R3
      AST_LOW_WINS_DM: assert property (@(posedge clk) disable iff (!rst_n)
         flow_q[2*p] |-> (dm_oe[p] && !dm_out[p])); // R3
      AST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_q[2*p+1:2*p] == 2'b00 && flow_q[2*p+1:2*p] == 2'b00) |-> (!dp_oe[p] && !dm_oe[p])); // R1
   end

   AST_BUS_RST_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> (ctrl_q == '0)); // R5
   AST_BUS_RST_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rst && !flow_wr) |=> $stable(flow_q)); // R5
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == ADDR_W'(ADDR_SE0)) |-> (rdata[DATA_W-1:NPORTS] == '0)); // R6
endmodule

// File: tb/hpo_port_override_test.sv
module hpo_port_override_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rst = 1'b0;
   logic [7:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [3:0] line_dp = 4'b0101;
   logic [3:0] line_dm = 4'b1010;
   logic [3:0] dp_oe, dp_out, dm_oe, dm_out;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   hpo_port_override uut (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .addr(addr), .wr_en(wr_en),
      .wdata(wdata), .rdata(rdata), .line_dp(line_dp), .line_dm(line_dm),
      .dp_oe(dp_oe), .dp_out(dp_out), .dm_oe(dm_oe), .dm_out(dm_out)
   );

   // {ctrl, force_low, dp_oe, dp_out, dm_oe, dm_out}
   localparam logic [31:0] VEC [9] = '{
      {8'h00, 8'h00, 4'b0000, 4'b0000, 4'b0000, 4'b0000},
      {8'hE4, 8'h00, 4'b1110, 4'b0010, 4'b1110, 4'b0100},
      {8'h55, 8'h00, 4'b1111, 4'b1111, 4'b1111, 4'b0000},
      {8'hAA, 8'h00, 4'b1111, 4'b0000, 4'b1111, 4'b1111},
      {8'hFF, 8'h00, 4'b1111, 4'b0000, 4'b1111, 4'b0000},
      {8'h55, 8'h02, 4'b1111, 4'b1110, 4'b1111, 4'b0000},
      {8'h00, 8'h81, 4'b1000, 4'b0000, 4'b0001, 4'b0000},
      {8'hAA, 8'h04, 4'b1111, 4'b0000, 4'b1111, 4'b1101},
      {8'h1B, 8'h00, 4'b0111, 4'b0100, 4'b0111, 4'b0010}
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] r;
      repeat (3) @(negedge clk);
      // R4: reset state
      rd(8'd0, r); chk("R4 ctrl after reset", {24'h0, r}, 32'h0);
      rd(8'd1, r); chk("R4 force-low after reset", {24'h0, r}, 32'h0);
      chk("R4 lines released", {16'h0, dp_oe, dp_out, dm_oe, dm_out}, 32'h0);
      rst_n = 1'b1;

      // R1/R2/R3/R9: vector table
      foreach (VEC[i]) begin
         wr(8'd0, VEC[i][31:24]);
         wr(8'd1, VEC[i][23:16]);
         #1;
         chk($sformatf("R1/R2/R3 drive vector %0d", i),
             {16'h0, dp_oe, dp_out, dm_oe, dm_out}, {16'h0, VEC[i][15:0]});
         rd(8'd0, r); chk("R9 ctrl readback", {24'h0, r}, {24'h0, VEC[i][31:24]});
         rd(8'd1, r); chk("R9 force-low readback", {24'h0, r}, {24'h0, VEC[i][23:16]});
      end
      wr(8'd0, 8'h00);
      wr(8'd1, 8'h00);

      // line state settled: ports 1,3 differential 1, ports 2,4 differential 0
      repeat (4) @(negedge clk);
      rd(8'd3, r); chk("R7 data initial", {24'h0, r}, 32'h05);
      rd(8'd2, r); chk("R6 se0 idle", {24'h0, r}, 32'h00);

      // R8: read-only and unmapped
      wr(8'd3, 8'hFF);
      wr(8'd2, 8'hFF);
      rd(8'd3, r); chk("R8 data write ignored", {24'h0, r}, 32'h05);
      rd(8'd2, r); chk("R8 se0 write ignored", {24'h0, r}, 32'h00);
      rd(8'd4, r); chk("R8 unmapped 4", {24'h0, r}, 32'h0);
      rd(8'hFF, r); chk("R8 unmapped FF", {24'h0, r}, 32'h0);

      // R6: latency of three rising edges
      @(negedge clk);
      line_dp[0] = 1'b0; line_dm[0] = 1'b0;
      repeat (2) @(negedge clk);
      rd(8'd2, r); chk("R6 se0 not before third edge", {24'h0, r}, 32'h00);
      @(negedge clk);
      rd(8'd2, r); chk("R6 se0 after third edge", {24'h0, r}, 32'h01);
      rd(8'd3, r); chk("R7 data held in SE0", {24'h0, r}, 32'h05);

      // R7: differential 0 then SE0 then both high
      line_dm[0] = 1'b1;
      repeat (4) @(negedge clk);
      rd(8'd3, r); chk("R7 data follows diff 0", {24'h0, r}, 32'h04);
      rd(8'd2, r); chk("R6 se0 cleared", {24'h0, r}, 32'h00);
      line_dm[0] = 1'b0;
      repeat (4) @(negedge clk);
      rd(8'd3, r); chk("R7 data held in SE0 again", {24'h0, r}, 32'h04);
      line_dp[0] = 1'b1; line_dm[0] = 1'b1;
      repeat (4) @(negedge clk);
      rd(8'd2, r); chk("R7 both high not SE0", {24'h0, r}, 32'h00);
      rd(8'd3, r); chk("R7 both high holds data", {24'h0, r}, 32'h04);
      line_dm[0] = 1'b0;
      repeat (4) @(negedge clk);
      rd(8'd3, r); chk("R7 data follows diff 1", {24'h0, r}, 32'h05);

      // R5: bus reset
      line_dp[0] = 1'b0;
      repeat (4) @(negedge clk);
      wr(8'd0, 8'hFF);
      wr(8'd1, 8'h0F);
      bus_rst = 1'b1;
      @(negedge clk);
      bus_rst = 1'b0;
      rd(8'd0, r); chk("R5 ctrl cleared", {24'h0, r}, 32'h00);
      rd(8'd1, r); chk("R5 force-low kept", {24'h0, r}, 32'h0F);
      rd(8'd2, r); chk("R5 se0 cleared", {24'h0, r}, 32'h00);
      rd(8'd3, r); chk("R5 data cleared", {24'h0, r}, 32'h00);
      chk("R5 R3 lines after bus reset", {16'h0, dp_oe, dp_out, dm_oe, dm_out},
          {16'h0, 4'b0011, 4'b0000, 4'b0011, 4'b0000});
      repeat (4) @(negedge clk);
      rd(8'd3, r); chk("R5 cleared data held in SE0", {24'h0, r}, 32'h04);
      rd(8'd2, r); chk("R6 se0 after bus reset", {24'h0, r}, 32'h01);

      // R4: chip reset clears force-low
      rst_n = 1'b0;
      #1;
      rd(8'd1, r); chk("R4 force-low cleared by chip reset", {24'h0, r}, 32'h00);
      rd(8'd3, r); chk("R4 data cleared by chip reset", {24'h0, r}, 32'h00);
      chk("R4 lines released by chip reset", {16'h0, dp_oe, dp_out, dm_oe, dm_out}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule